// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates among thirteen interrupt sources for an 8051-style processor core. Each source presents a pending flag, an enable bit and a one-bit priority level. A global enable gates all of them. Among the sources that are pending and enabled, the controller prefers any high-level source over every low-level one. Inside a level, a fixed natural order breaks ties. The winner's vector address is placed on `vec`, and `irq` is raised toward the core.

The core accepts the request with `ack`. At that point the controller records the level of the accepted request in one of two in-service bits. While a low-level handler runs, only a high-level request may interrupt it. While a high-level handler runs, nothing may interrupt it. The core signals the end of a handler with the `reti` strobe, which retires the highest level currently in service. Source-side edge or level detection and the core itself are outside this block.

Top module: `intc_two_level`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `irq`, `vec`, `isr_hi` and `isr_lo` are all zero.
- R2: A source takes part in arbitration only when `glb_en`, its `src_req` bit and its `src_en` bit are all 1. With no such source, `irq` stays 0.
- R3: Natural order, highest first, by bit index: 0 power-fail, 1 external 0, 2 timer 0, 3 external 1, 4 timer 1, 5 serial 0, 6 timer 2, 7 serial 1, 8 to 11 external 2 to 5, 12 watchdog. Within one level the lowest eligible index wins.
- R4: A source with its `src_hi` bit set wins over every source with `src_hi` clear, whatever their natural order.
- R5: The vector for index 0 is 33h. Indices 1 to 6 map to 03h, 0Bh, 13h, 1Bh, 23h and 2Bh. Index 7 maps to 3Bh. Indices 8 to 12 map to 43h, 4Bh, 53h, 5Bh and 63h.
- R6: When the controller is idle and a source becomes eligible, `irq` rises one clock later, with the winner's vector on `vec` in the same cycle.
- R7: Once `irq` is high, `irq` and `vec` hold their values until `ack` is sampled high, even if the sources change.
- R8: When `ack` is sampled with `irq` high, `irq` is low in the next cycle. In that same cycle, `isr_hi` is set for a high-level winner, or `isr_lo` for a low-level winner.
- R9: With `isr_lo` set, only high-level sources may raise `irq`. With `isr_hi` set, no source raises `irq`.
- R10: A `reti` strobe clears `isr_hi` if it is set. Otherwise it clears `isr_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_req | input | 13 | Pending flag per source, natural-order index |
| src_en | input | 13 | Enable bit per source |
| src_hi | input | 13 | Priority level per source, 1 = high |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | Request strobe to the core |
| vec | output | 8 | Vector address of the presented request |
| isr_hi | output | 1 | High-level handler in service |
| isr_lo | output | 1 | Low-level handler in service |

## Verification
The bench sweeps every ordered pair of sources under all four level combinations. This exposes a reversed scan direction, which would pick the watchdog over power-fail, and a level override that was ignored, which would let natural order beat priority. It also checks each of the thirteen vectors, where an off-by-one in the irregular map would misplace serial 1 or power-fail. The nesting sequences try a same-level request during a low handler, which a broken in-service check would let through. They also run `reti` with both levels active, where a wrong clear order would drop the low handler first. A source swap during a pending request catches a vector that drifts before `ack`.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC = 13;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned LEVELS  = 2;

  // Vectors are spaced by 8 bytes; the first-priority source sits in the
  // slot just below serial 1, the rest follow index order around it.
  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
    int unsigned slot;
    if (idx == 0)     slot = 7;
    else if (idx < 7) slot = idx;
    else              slot = idx + 1;
    return VEC_W'(8 * slot - 5);
  endfunction
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N  = 13,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_svc_track.sv
module intc_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic set_hi,
  input  logic clr_en,
  output logic svc_hi,
  output logic svc_lo
);
  logic hi_q, lo_q, hi_d, lo_d, upd_en;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    upd_en = set_en | clr_en;
    if (clr_en) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (set_en) begin
      if (set_hi) hi_d = 1'b1;
      else        lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (upd_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign svc_hi = hi_q;
  assign svc_lo = lo_q;
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_hi,
  input  logic             ack,
  input  logic             reti,
  output logic             irq,
  output logic [VEC_W-1:0] vec,
  output logic             isr_hi,
  output logic             isr_lo
);
  logic rst_int_n;
  logic [N_SRC-1:0] elig;
  logic [LEVELS-1:0][N_SRC-1:0] cand;
  logic [LEVELS-1:0]            phit;
  logic [LEVELS-1:0][IDX_W-1:0] pidx;
  logic take_hi, take_lo;
  logic irq_q, irq_d, lvl_q, lvl_d, load_en;
  logic [VEC_W-1:0] vec_q, vec_d;

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  always_comb begin
    elig    = src_req & src_en & {N_SRC{glb_en}};
    cand[0] = elig & ~src_hi;
    cand[1] = elig & src_hi;
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    intc_prio_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
      .cand(cand[l]), .hit(phit[l]), .idx(pidx[l])
    );
  end

  always_comb begin
    take_hi = phit[1] && !isr_hi;
    take_lo = phit[0] && !isr_hi && !isr_lo;
    irq_d   = irq_q;
    vec_d   = vec_q;
    lvl_d   = lvl_q;
    load_en = 1'b0;
    if (irq_q) begin
      if (ack) begin
        irq_d   = 1'b0;
        load_en = 1'b1;
      end
    end else if (take_hi || take_lo) begin
      irq_d   = 1'b1;
      lvl_d   = take_hi;
      vec_d   = src_vector(32'(take_hi ? pidx[1] : pidx[0]));
      load_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_en) begin
      irq_q <= irq_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  intc_svc_track u_svc (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(irq_q & ack), .set_hi(lvl_q), .clr_en(reti),
    .svc_hi(isr_hi), .svc_lo(isr_lo)
  );

  assign irq = irq_q;
  assign vec = vec_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       ack,
  input logic       reti,
  input logic       irq,
  input logic [7:0] vec,
  input logic       isr_hi,
  input logic       isr_lo,
  input logic       lvl
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq && $stable(vec));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack |=> !irq);

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack && !reti |=> (lvl ? isr_hi : isr_lo));

  assert_hi_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> !irq);

  assert_lo_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && isr_lo |-> lvl);

  assert_reti_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !ack && isr_hi |=> !isr_hi && (isr_lo == $past(isr_lo)));

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(glb_en));
endmodule

bind intc_two_level intc_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .glb_en(glb_en), .ack(ack), .reti(reti),
  .irq(irq), .vec(vec), .isr_hi(isr_hi), .isr_lo(isr_lo), .lvl(lvl_q)
);

// File: tb/tb_intc_two_level.sv
module tb_intc_two_level;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        glb_en = 0;
  logic [12:0] src_req = '0, src_en = '0, src_hi = '0;
  logic        ack = 0, reti = 0;
  logic        irq, isr_hi, isr_lo;
  logic [7:0]  vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_two_level dut (.clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .src_req(src_req), .src_en(src_en), .src_hi(src_hi), .ack(ack),
    .reti(reti), .irq(irq), .vec(vec), .isr_hi(isr_hi), .isr_lo(isr_lo));

  function automatic logic [7:0] exp_vec(input int i);
    case (i)
      0: return 8'h33;  1: return 8'h03;  2: return 8'h0B;  3: return 8'h13;
      4: return 8'h1B;  5: return 8'h23;  6: return 8'h2B;  7: return 8'h3B;
      8: return 8'h43;  9: return 8'h4B; 10: return 8'h53; 11: return 8'h5B;
      default: return 8'h63;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // one arbitration round from idle; exp winner computed here
  task automatic run_case(input logic [12:0] rq, en, hi, input logic g);
    int win = -1; logic wl = 0;
    for (int k = 0; k < 13; k++)
      if (win < 0 && g && rq[k] && en[k] && hi[k]) begin win = k; wl = 1; end
    for (int k = 0; k < 13; k++)
      if (win < 0 && g && rq[k] && en[k]) begin win = k; wl = 0; end
    glb_en = g; src_req = rq; src_en = en; src_hi = hi;
    step();
    chk("R6 irq", irq, win >= 0);
    if (win >= 0) begin
      chk(wl ? "R4 R5 vec" : "R3 R5 vec", vec, exp_vec(win));
      ack = 1; src_req = '0;
      step();
      ack = 0;
      chk("R8 irq drop", irq, 0);
      chk("R8 isr", {isr_hi, isr_lo}, wl ? 2'b10 : 2'b01);
      reti = 1;
      step();
      reti = 0;
      chk("R10 clear", {isr_hi, isr_lo}, 0);
    end else begin
      src_req = '0;
      step();
      chk("R2 masked", irq, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    src_req = '1; src_en = '1; glb_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset", {irq, vec, isr_hi, isr_lo}, 0);
    src_req = '0;
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {irq, vec, isr_hi, isr_lo}, 0);
    repeat (3) @(negedge clk);

    // R3 R4 R5: all pairs, all level combinations
    for (int i = 0; i < 13; i++)
      for (int j = 0; j < 13; j++)
        for (int hp = 0; hp < 4; hp++) begin
          logic [12:0] h = '0;
          h[i] = hp[0]; h[j] = hp[1];
          run_case((13'd1 << i) | (13'd1 << j), '1, h, 1'b1);
        end

    // R2: per-source mask and global enable
    for (int i = 0; i < 13; i++) begin
      run_case(13'd1 << i, ~(13'd1 << i), '0, 1'b1);
      run_case(13'd1 << i, '1, 13'd1 << i, 1'b0);
      run_case((13'd1 << i) | 13'h1000, ~(13'd1 << i), '0, 1'b1);
    end

    // R7: pending request keeps its vector while sources change
    glb_en = 1; src_en = '1; src_hi = '0; src_req = 13'h0010;
    step();
    chk("R7 raise", {irq, vec}, {1'b1, 8'h1B});
    src_req = 13'h0001; src_hi = 13'h0001;
    repeat (3) step();
    chk("R7 hold", {irq, vec}, {1'b1, 8'h1B});
    ack = 1; src_req = '0; step(); ack = 0;
    chk("R8 low set", {isr_hi, isr_lo}, 2'b01);

    // R9: nesting under a low handler
    src_hi = '0; src_req = 13'h0001;
    repeat (3) step();
    chk("R9 low blocked", irq, 0);
    src_hi = 13'h1000; src_req = 13'h1001;
    step();
    chk("R9 high preempts", {irq, vec}, {1'b1, 8'h63});
    ack = 1; src_req = '0; step(); ack = 0;
    chk("R8 nested", {isr_hi, isr_lo}, 2'b11);
    src_hi = '1; src_req = 13'h0001;
    repeat (3) step();
    chk("R9 high blocked", irq, 0);
    src_req = '0;

    // R10: clear order
    reti = 1; step(); reti = 0;
    chk("R10 hi first", {isr_hi, isr_lo}, 2'b01);
    reti = 1; step(); reti = 0;
    chk("R10 lo next", {isr_hi, isr_lo}, 2'b00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule